// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block models, on the device side, the status word a flash array returns to reads while an embedded program or erase is running. Internal events drive it: a program start, an accepted sector erase command, a chip erase start, an operation-complete pulse, a time-limit overrun, erase suspend and resume, and a clear command. It combines these with the read strobe and the sector field of the read address. It then overrides bits 7, 6, 5 and 3 of the data coming from the array. The other bits, and every bit when no operation is active, pass straight through from the array data input.

Sector erase commands open an acceptance window of `WIN_CYCLES` clock cycles. Each further sector erase command accepted inside the window adds its sector to the erase set and restarts the full window. When the window expires, the erase begins and bit 3 rises. Commands are then locked out until the operation finishes or is cleared. A chip erase skips the window and marks every sector at once.

The status word is {bit7, bit6, bit5, array[4], bit3, array[2:0]}. Bit 6 is the read toggle, bit 5 the time-limit flag and bit 3 the erase-running flag.

Top module: `flash_wstat_gen`

## Requirements
- R1: With no operation active, rd_data equals array_data for every read address.
- R2: During a program, bit 7 reads as the complement of the wr_msb value captured with prog_start, and bit 3 reads 0.
- R3: While an operation is active, bit 6 inverts after every cycle in which rd_stb is high, so successive reads differ. Once the operation ends, reads return array data and bit 6 no longer toggles.
- R4: During any erase phase (window open or erase running), bit 7 reads 0.
- R5: After the last accepted sector erase command, bit 3 reads 0 for exactly WIN_CYCLES cycles and then reads 1.
- R6: A sector erase command accepted while the window is open (bit 3 still 0) restarts the full window and adds its sector to the erase set.
- R7: Once bit 3 is 1, sector erase, chip erase and program commands have no effect on the status or the erase set.
- R8: A chip erase sets bit 3 to 1 in the first cycle after it starts and places every sector in the erase set.
- R9: time_limit_hit during a program or a running erase sets bit 5. Bit 5 stays 1 through op_done, and bit 6 keeps toggling, until clear_op returns the block to pass-through.
- R10: In suspend, reads whose sector is in the erase set return bit 7 = 1, a toggling bit 6, bit 5 = 0 and bit 3 = 0. Reads from other sectors return array_data. resume_req restores the running-erase status.
- R11: op_done ends a program or a running erase that has not overrun, and returns the block to pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | Embedded program begins |
| wr_msb | input | 1 | Bit 7 of the data being programmed |
| sect_erase_cmd | input | 1 | Sector erase command accepted by the decoder |
| se_sect | input | SECT_W | Sector addressed by the sector erase command |
| chip_erase_start | input | 1 | Chip erase begins |
| op_done | input | 1 | Embedded operation finished |
| time_limit_hit | input | 1 | Operation exceeded its time limit |
| susp_req | input | 1 | Erase suspend request |
| resume_req | input | 1 | Erase resume request |
| clear_op | input | 1 | Clear command, abandons the operation |
| rd_stb | input | 1 | Read strobe, one per read |
| rd_sect | input | SECT_W | Sector field of the read address |
| array_data | input | 8 | Data from the array stub |
| rd_data | output | 8 | Read data with status bits merged |

## Verification
A wrong window count shows up on bit 3 within WIN_CYCLES cycles of the last accepted sector command, as an early or late rise. The bench sweeps every command gap across the window boundary to catch it. A corrupted erase set only becomes visible after a suspend, when a sector reads status instead of array data or the reverse, so every test ends with a suspend and a read of every sector. A toggle flop that misses a strobe is caught on the very next read, because each status read is compared with the bit 6 value of the read before it.

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen #(
  parameter int SECT_W     = 3,
  parameter int WIN_CYCLES = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              wr_msb,
  input  logic              sect_erase_cmd,
  input  logic [SECT_W-1:0] se_sect,
  input  logic              chip_erase_start,
  input  logic              op_done,
  input  logic              time_limit_hit,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic              clear_op,
  input  logic              rd_stb,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic [7:0]        array_data,
  output logic [7:0]        rd_data
);
  localparam int NSECT = 1 << SECT_W;
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_WIN, S_ERASE, S_SUSP} st_t;

  st_t              state;
  logic             tog, fail, pbit;
  logic [NSECT-1:0] mask;
  logic [CNT_W-1:0] cnt;

  wire busy    = (state == S_PROG) || (state == S_WIN) || (state == S_ERASE);
  wire in_susp = (state == S_SUSP) && mask[rd_sect];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      fail  <= 1'b0;
      pbit  <= 1'b0;
      mask  <= '0;
      cnt   <= '0;
    end else if (clear_op) begin
      state <= S_IDLE;
      fail  <= 1'b0;
      mask  <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (prog_start) begin
            state <= S_PROG;
            pbit  <= wr_msb;
          end else if (chip_erase_start) begin
            state <= S_ERASE;
            mask  <= '1;
          end else if (sect_erase_cmd) begin
            state <= S_WIN;
            mask  <= NSECT'(1) << se_sect;
            cnt   <= CNT_LOAD;
          end
        end
        S_PROG: begin
          if (time_limit_hit) fail <= 1'b1;
          else if (op_done && !fail) state <= S_IDLE;
        end
        S_WIN: begin
          if (sect_erase_cmd) begin
            mask <= mask | (NSECT'(1) << se_sect);
            cnt  <= CNT_LOAD;
          end else if (cnt == '0) begin
            state <= S_ERASE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ERASE: begin
          if (time_limit_hit) fail <= 1'b1;
          else if (op_done && !fail) begin
            state <= S_IDLE;
            mask  <= '0;
          end else if (susp_req && !fail) state <= S_SUSP;
        end
        S_SUSP: if (resume_req) state <= S_ERASE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        tog <= 1'b0;
    else if (clear_op)                 tog <= 1'b0;
    else if (rd_stb && (busy || in_susp)) tog <= ~tog;
  end

  always_comb begin
    rd_data = array_data;
    if (busy) begin
      rd_data[7] = (state == S_PROG) ? ~pbit : 1'b0;
      rd_data[6] = tog;
      rd_data[5] = fail;
      rd_data[3] = (state == S_ERASE);
    end else if (in_susp) begin
      rd_data[7] = 1'b1;
      rd_data[6] = tog;
      rd_data[5] = 1'b0;
      rd_data[3] = 1'b0;
    end
  end

  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> rd_data == array_data);
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && !clear_op) |=> tog != $past(tog));
  p_win_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WIN && cnt == '0 && !sect_erase_cmd && !clear_op) |=> state == S_ERASE);
  p_win_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WIN && sect_erase_cmd && !clear_op) |=> (state == S_WIN && cnt == CNT_LOAD));
  p_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERASE && !clear_op && !op_done) |=> $stable(mask));
  p_chip_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && chip_erase_start && !prog_start && !clear_op) |=> (state == S_ERASE && &mask));
  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear_op) |=> fail);
endmodule

// File: tb/flash_wstat_gen_tb.sv
module flash_wstat_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 2;
  localparam int W  = 8;

  logic clk = 0, rst_n = 0;
  logic prog_start = 0, wr_msb = 0, sect_erase_cmd = 0, chip_erase_start = 0;
  logic op_done = 0, time_limit_hit = 0, susp_req = 0, resume_req = 0, clear_op = 0;
  logic rd_stb = 0;
  logic [SW-1:0] se_sect = 0, rd_sect = 0;
  logic [7:0] array_data, rd_data;
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic [7:0] arr(input logic [SW-1:0] s);
    return 8'(s) * 8'd29 + 8'd11;
  endfunction
  assign array_data = arr(rd_sect);

  function automatic [7:0] sw(input logic b7, b6, b5, b3, input logic [7:0] a);
    return {b7, b6, b5, a[4], b3, a[2:0]};
  endfunction

  flash_wstat_gen #(.SECT_W(SW), .WIN_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .wr_msb(wr_msb),
    .sect_erase_cmd(sect_erase_cmd), .se_sect(se_sect),
    .chip_erase_start(chip_erase_start), .op_done(op_done),
    .time_limit_hit(time_limit_hit), .susp_req(susp_req), .resume_req(resume_req),
    .clear_op(clear_op), .rd_stb(rd_stb), .rd_sect(rd_sect),
    .array_data(array_data), .rd_data(rd_data));

  task automatic check(input string tag, input logic [7:0] got, exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [SW-1:0] s, output logic [7:0] v);
    rd_sect = s; rd_stb = 1; #1; v = rd_data;
    step(); rd_stb = 0;
  endtask

  task automatic peek(input logic [SW-1:0] s, output logic [7:0] v);
    rd_sect = s; #1; v = rd_data;
  endtask

  task automatic suspend_scan(input logic [3:0] set, input string tag);
    logic [7:0] v;
    logic p;
    susp_req = 1; step(); susp_req = 0;
    for (int s = 0; s < 4; s++) begin
      if (set[s]) begin
        rd(SW'(s), v); p = v[6];
        check({tag, " R10 susp sect"}, v, sw(1, p, 0, 0, arr(SW'(s))));
        rd(SW'(s), v);
        check({tag, " R10 susp toggle"}, v, sw(1, ~p, 0, 0, arr(SW'(s))));
      end else begin
        rd(SW'(s), v);
        check({tag, " R10/R7 other sect"}, v, arr(SW'(s)));
      end
    end
    resume_req = 1; step(); resume_req = 0;
    peek(0, v);
    check({tag, " R10 resume"}, v, sw(0, v[6], 0, 1, arr(0)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) step();
    rst_n = 1; step();
    for (int s = 0; s < 4; s++) begin
      peek(SW'(s), v);
      check("R1 reset pass-through", v, arr(SW'(s)));
    end

    for (int d = 0; d < 256; d++) begin
      logic [SW-1:0] s;
      s = SW'(d);
      wr_msb = d[7]; prog_start = 1; step(); prog_start = 0;
      rd(s, v);
      check("R2 program status", v, sw(~d[7], v[6], 0, 0, arr(s)));
      rd(s, v2);
      check("R3 program toggle", v2, sw(~d[7], ~v[6], 0, 0, arr(s)));
      op_done = 1; step(); op_done = 0;
      rd(s, v); rd(s, v2);
      check("R11 done pass-through", v, arr(s));
      check("R3 no toggle after done", v2, arr(s));
    end

    for (int g = 0; g <= W + 1; g++) begin
      logic acc;
      acc = (g <= W - 1);
      se_sect = 0; sect_erase_cmd = 1; step(); sect_erase_cmd = 0;
      repeat (g) step();
      se_sect = 1; sect_erase_cmd = 1; step(); sect_erase_cmd = 0;
      if (acc) begin
        for (int m = 0; m < W; m++) begin
          peek(0, v);
          check("R5/R6 window open bit3", v, sw(0, v[6], 0, 0, arr(0)));
          step();
        end
      end
      peek(0, v);
      check("R4/R5 erase running", v, sw(0, v[6], 0, 1, arr(0)));
      wr_msb = 0; prog_start = 1; chip_erase_start = 1; step();
      prog_start = 0; chip_erase_start = 0;
      rd(2, v);
      check("R7 commands ignored", v, sw(0, v[6], 0, 1, arr(2)));
      suspend_scan(acc ? 4'b0011 : 4'b0001, "win");
      op_done = 1; step(); op_done = 0;
      peek(0, v);
      check("R11 erase done", v, arr(0));
    end

    chip_erase_start = 1; step(); chip_erase_start = 0;
    rd(3, v);
    check("R8 chip bit3", v, sw(0, v[6], 0, 1, arr(3)));
    suspend_scan(4'b1111, "chip");
    op_done = 1; step(); op_done = 0;

    wr_msb = 1; prog_start = 1; step(); prog_start = 0;
    time_limit_hit = 1; step(); time_limit_hit = 0;
    rd(1, v);
    check("R9 overrun bit5", v, sw(0, v[6], 1, 0, arr(1)));
    op_done = 1; step(); op_done = 0;
    rd(1, v2);
    check("R9 sticky and toggling", v2, sw(0, ~v[6], 1, 0, arr(1)));
    clear_op = 1; step(); clear_op = 0;
    peek(1, v);
    check("R9 clear", v, arr(1));

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule